// File: doc/BRIEF.md
# Shared Cache Error Capture and Injection Unit

This block sits beside a shared cache and records what its ECC and parity checkers report. Each error event arrives as a one-cycle pulse. The pulse carries the requester (source), the transaction type, the error kind, the failing address, the set index and the way. The unit keeps a saturating count of correctable errors and a separate one of uncorrectable errors. It also keeps a detailed snapshot of a single error. That snapshot stays locked until software clears it, so a burst of later errors cannot overwrite the first one. Software reads all state through a simple 32-bit register port: a word index, a write strobe, write data and combinational read data.

The unit also provides a fault-injection facility for testing the error path. Software clears the control word, loads a data mask and then writes a target word address together with the arm bit. The next cache access to that address gets the mask on `inj_flip` for the cache to XOR into its data. The unit then disarms itself.

Top module: `cecap_top`

## Requirements
- R1: After reset every register reads zero and `inj_flip` is zero; register indices 6 and 7 always read zero.
- R2: One cycle after an event of kind 0, the correctable count in bits [15:0] of index 0 has grown by one. Any nonzero kind (1 = uncorrectable ECC, 2 = tag parity, 3 = reserved) increments the uncorrectable count in bits [31:16] instead.
- R3: Each count saturates at 0xFFFF and stays there under further events.
- R4: Writing index 0 with bit 0 set zeroes both counts. Writing index 0 with bit 0 clear has no effect. An event in the same cycle as a clearing write is counted after the clear, so that count reads 1.
- R5: An event that arrives while the snapshot is invalid is captured. Index 1 then holds valid in [0], source in [3:1], transaction type in [6:4] (0 data read, 1 instruction read, 2 clean/flush, 3 eviction, 4 read-modify-write) and kind in [9:8]. Index 2 holds the address. Index 3 holds the set index in its low bits and the way from bit 16 up.
- R6: While the snapshot is valid, later events leave indices 1, 2 and 3 unchanged.
- R7: Writing index 1 with bit 0 set clears the snapshot to zero. An event in that same cycle is captured instead. Writing index 1 with bit 0 clear has no effect.
- R8: Bit 7 of index 1 is set when the captured source is above 3 (I/O path) and clear for sources 0 to 3 (processor cores).
- R9: Index 4 holds the injection mask. A write to it is ignored while injection is armed.
- R10: Index 5 holds the arm bit in [0] and the target word address in [31:2]. While armed, `inj_flip` equals the mask in the same cycle as any access whose address bits [31:2] match the target. Otherwise `inj_flip` is zero.
- R11: After a matching access the unit disarms on the next cycle, and later accesses see zero on `inj_flip`. A write to index 5 in the same cycle as a matching access takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Error event pulse |
| ev_src | input | 3 | Requester of the failing access |
| ev_txn | input | 3 | Transaction type |
| ev_kind | input | 2 | Error kind |
| ev_addr | input | 32 | Failing address |
| ev_index | input | IDX_W | Set index |
| ev_way | input | WAY_W | Way |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| acc_valid | input | 1 | Cache access in this cycle |
| acc_addr | input | 32 | Cache access address |
| inj_flip | output | 32 | Mask to XOR into the accessed data |

## Verification
Three pairs of functions can fall in the same cycle: a software clear and a new error event, for both the counters and the snapshot, and a control-word write and a matching access. The bench drives each pair in one cycle on purpose. A behavioural model applies the clear first and then the event, and lets the write override the self-disarm. It compares the register read-back and `inj_flip` after every clock, so the order in which the design resolves each collision is judged directly from the value read back.

// File: rtl/cecap_pkg.sv
package cecap_pkg;
    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        RG_CNT  = 3'd0,
        RG_ATTR = 3'd1,
        RG_ADDR = 3'd2,
        RG_LOC  = 3'd3,
        RG_MASK = 3'd4,
        RG_CTL  = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [1:0] kind;
        logic       io;
        logic [2:0] txn;
        logic [2:0] src;
    } attr_t;
endpackage

// File: rtl/cecap_counter.sv
module cecap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.cnt = '0;
        if (inc && st_d.cnt != MAX) st_d.cnt = st_d.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX && inc && !clr) |=> cnt == MAX);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> cnt == '0);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt != MAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/cecap_capture.sv
module cecap_capture
    import cecap_pkg::*;
#(
    parameter int IDX_W = 12,
    parameter int WAY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic [2:0]       src,
    input  logic [2:0]       txn,
    input  logic [1:0]       kind,
    input  logic [REG_W-1:0] addr,
    input  logic [IDX_W-1:0] idx,
    input  logic [WAY_W-1:0] way,
    input  logic             clr,
    output logic             valid,
    output attr_t            attr,
    output logic [REG_W-1:0] cap_addr,
    output logic [IDX_W-1:0] cap_idx,
    output logic [WAY_W-1:0] cap_way
);
    typedef struct packed {
        logic             valid;
        attr_t            attr;
        logic [REG_W-1:0] addr;
        logic [IDX_W-1:0] idx;
        logic [WAY_W-1:0] way;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d = '0;
        if (ev && !st_d.valid) begin
            st_d.valid     = 1'b1;
            st_d.attr.src  = src;
            st_d.attr.txn  = txn;
            st_d.attr.kind = kind;
            st_d.attr.io   = (src > 3'd3);
            st_d.addr      = addr;
            st_d.idx       = idx;
            st_d.way       = way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid    = st_q.valid;
    assign attr     = st_q.attr;
    assign cap_addr = st_q.addr;
    assign cap_idx  = st_q.idx;
    assign cap_way  = st_q.way;

    p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clr) |=> ($stable(attr) && $stable(cap_addr) && $stable(cap_idx) && $stable(cap_way)));
    p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && (!valid || clr)) |=> (valid && cap_addr == $past(addr)));
    p_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev) |=> (!valid && cap_addr == '0));
endmodule

// File: rtl/cecap_inject.sv
module cecap_inject
    import cecap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             acc_valid,
    input  logic [REG_W-1:0] acc_addr,
    output logic [REG_W-1:0] flip,
    output logic [REG_W-1:0] mask_rd,
    output logic [REG_W-1:0] ctl_rd
);
    localparam int TGT_W = REG_W - 2;

    typedef struct packed {
        logic             armed;
        logic [TGT_W-1:0] tgt;
        logic [REG_W-1:0] mask;
    } st_t;

    st_t  st_d, st_q;
    logic hit;

    always_comb begin
        hit  = acc_valid && st_q.armed && (acc_addr[REG_W-1:2] == st_q.tgt);
        st_d = st_q;
        if (mask_we && !st_q.armed) st_d.mask = wdata;
        if (ctl_we) begin
            st_d.armed = wdata[0];
            st_d.tgt   = wdata[REG_W-1:2];
        end else if (hit) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flip    = hit ? st_q.mask : '0;
    assign mask_rd = st_q.mask;
    assign ctl_rd  = {st_q.tgt, 1'b0, st_q.armed};

    p_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && flip != '0 && !ctl_we) |=> ctl_rd[0] == 1'b0);
    p_mask_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd[0] |=> $stable(mask_rd));
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rd[0] || !acc_valid) |-> flip == '0);
endmodule

// File: rtl/cecap_top.sv
module cecap_top
    import cecap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IDX_W = 12,
    parameter int WAY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [2:0]       ev_src,
    input  logic [2:0]       ev_txn,
    input  logic [1:0]       ev_kind,
    input  logic [31:0]      ev_addr,
    input  logic [IDX_W-1:0] ev_index,
    input  logic [WAY_W-1:0] ev_way,
    input  logic             reg_we,
    input  logic [2:0]       reg_idx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             acc_valid,
    input  logic [31:0]      acc_addr,
    output logic [31:0]      inj_flip
);
    localparam int HALF    = REG_W / 2;
    localparam int N_CNT   = 2;
    localparam int WAY_LSB = HALF;

    logic             cnt_clr, cap_clr, mask_we, ctl_we;
    logic [CNT_W-1:0] cnt_val [N_CNT];
    logic             cap_valid;
    attr_t            cap_attr;
    logic [REG_W-1:0] cap_addr;
    logic [IDX_W-1:0] cap_idx;
    logic [WAY_W-1:0] cap_way;
    logic [REG_W-1:0] mask_rd, ctl_rd;

    always_comb begin
        cnt_clr = reg_we && (reg_idx == RG_CNT)  && reg_wdata[0];
        cap_clr = reg_we && (reg_idx == RG_ATTR) && reg_wdata[0];
        mask_we = reg_we && (reg_idx == RG_MASK);
        ctl_we  = reg_we && (reg_idx == RG_CTL);
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        logic inc;
        assign inc = ev_valid && ((g == 0) ? (ev_kind == 2'd0) : (ev_kind != 2'd0));
        cecap_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (inc),
            .cnt   (cnt_val[g])
        );
    end

    cecap_capture #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev_valid),
        .src      (ev_src),
        .txn      (ev_txn),
        .kind     (ev_kind),
        .addr     (ev_addr),
        .idx      (ev_index),
        .way      (ev_way),
        .clr      (cap_clr),
        .valid    (cap_valid),
        .attr     (cap_attr),
        .cap_addr (cap_addr),
        .cap_idx  (cap_idx),
        .cap_way  (cap_way)
    );

    cecap_inject u_inj (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .ctl_we    (ctl_we),
        .wdata     (reg_wdata),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .flip      (inj_flip),
        .mask_rd   (mask_rd),
        .ctl_rd    (ctl_rd)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            RG_CNT: begin
                reg_rdata[CNT_W-1:0]         = cnt_val[0];
                reg_rdata[HALF +: CNT_W]     = cnt_val[1];
            end
            RG_ATTR: begin
                reg_rdata[0]   = cap_valid;
                reg_rdata[3:1] = cap_attr.src;
                reg_rdata[6:4] = cap_attr.txn;
                reg_rdata[7]   = cap_attr.io;
                reg_rdata[9:8] = cap_attr.kind;
            end
            RG_ADDR: reg_rdata = cap_addr;
            RG_LOC: begin
                reg_rdata[IDX_W-1:0]        = cap_idx;
                reg_rdata[WAY_LSB +: WAY_W] = cap_way;
            end
            RG_MASK: reg_rdata = mask_rd;
            RG_CTL:  reg_rdata = ctl_rd;
            default: reg_rdata = '0;
        endcase
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (inj_flip == '0 && ctl_rd == '0 && !cap_valid));
    p_io_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (cap_attr.io == (cap_attr.src > 3'd3)));
endmodule

// File: tb/cecap_top_tb_top.sv
module cecap_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 12;
    localparam int WAY_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 0;
    logic [2:0] ev_src = 0, ev_txn = 0;
    logic [1:0] ev_kind = 0;
    logic [31:0] ev_addr = 0;
    logic [IDX_W-1:0] ev_index = 0;
    logic [WAY_W-1:0] ev_way = 0;
    logic reg_we = 0;
    logic [2:0] reg_idx = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic acc_valid = 0;
    logic [31:0] acc_addr = 0;
    logic [31:0] inj_flip;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int          m_cc, m_uc;
    bit          m_v;
    bit [2:0]    m_src, m_txn;
    bit [1:0]    m_kind;
    bit [31:0]   m_addr;
    bit [IDX_W-1:0] m_idx;
    bit [WAY_W-1:0] m_way;
    bit [31:0]   m_mask;
    bit          m_arm;
    bit [29:0]   m_tgt;

    always #(CLK_PERIOD/2) clk = ~clk;

    cecap_top #(.CNT_W(16), .IDX_W(IDX_W), .WAY_W(WAY_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_src(ev_src), .ev_txn(ev_txn), .ev_kind(ev_kind),
        .ev_addr(ev_addr), .ev_index(ev_index), .ev_way(ev_way),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .inj_flip(inj_flip)
    );

    function automatic bit m_hit();
        return acc_valid && m_arm && (acc_addr[31:2] == m_tgt);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cc = 0; m_uc = 0; m_v = 0; m_src = 0; m_txn = 0; m_kind = 0;
            m_addr = 0; m_idx = 0; m_way = 0; m_mask = 0; m_arm = 0; m_tgt = 0;
        end else begin
            bit hit;
            hit = m_hit();
            if (reg_we && reg_idx == 0 && reg_wdata[0]) begin m_cc = 0; m_uc = 0; end
            if (ev_valid) begin
                if (ev_kind == 0) begin if (m_cc < 65535) m_cc++; end
                else begin if (m_uc < 65535) m_uc++; end
            end
            if (reg_we && reg_idx == 1 && reg_wdata[0]) begin
                m_v = 0; m_src = 0; m_txn = 0; m_kind = 0; m_addr = 0; m_idx = 0; m_way = 0;
            end
            if (ev_valid && !m_v) begin
                m_v = 1; m_src = ev_src; m_txn = ev_txn; m_kind = ev_kind;
                m_addr = ev_addr; m_idx = ev_index; m_way = ev_way;
            end
            if (reg_we && reg_idx == 4 && !m_arm) m_mask = reg_wdata;
            if (reg_we && reg_idx == 5) begin m_arm = reg_wdata[0]; m_tgt = reg_wdata[31:2]; end
            else if (hit) m_arm = 0;
        end
    end

    function automatic bit [31:0] m_rd();
        bit [31:0] r = 0;
        case (reg_idx)
            0: r = {m_uc[15:0], m_cc[15:0]};
            1: r = {22'd0, m_kind, (m_src > 3), m_txn, m_src, m_v};
            2: r = m_addr;
            3: begin r[IDX_W-1:0] = m_idx; r[16 +: WAY_W] = m_way; end
            4: r = m_mask;
            5: r = {m_tgt, 1'b0, m_arm};
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic go(string req);
        bit [31:0] exp_rd, exp_fl;
        #1;
        exp_rd = m_rd();
        exp_fl = m_hit() ? m_mask : 32'd0;
        checks++;
        if (reg_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s idx %0d rdata actual %h expected %h", req, reg_idx, reg_rdata, exp_rd);
        end
        checks++;
        if (inj_flip !== exp_fl) begin
            errors++;
            $display("FAIL %s inj_flip actual %h expected %h", req, inj_flip, exp_fl);
        end
        @(negedge clk);
        ev_valid = 0; reg_we = 0; acc_valid = 0;
    endtask

    task automatic ev(logic [2:0] s, logic [2:0] t, logic [1:0] k, logic [31:0] a,
                      logic [IDX_W-1:0] i, logic [WAY_W-1:0] w);
        ev_valid = 1; ev_src = s; ev_txn = t; ev_kind = k; ev_addr = a; ev_index = i; ev_way = w;
    endtask

    task automatic wr(logic [2:0] i, logic [31:0] d);
        reg_we = 1; reg_idx = i; reg_wdata = d;
    endtask

    task automatic rd(logic [2:0] i);
        reg_idx = i;
    endtask

    initial begin
        #(CLK_PERIOD * 250000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values, including unused indices
        for (int i = 0; i < 8; i++) begin rd(i[2:0]); go("R1"); end

        // R2: counting by kind; R5/R8: first event captured
        ev(3'd5, 3'd4, 2'd0, 32'hDEAD_BEE0, 12'hABC, 4'h9); rd(0); go("R2");
        rd(0); go("R2");
        rd(1); go("R5 R8");
        rd(2); go("R5");
        rd(3); go("R5");
        ev(3'd2, 3'd1, 2'd1, 32'h1111_0000, 12'h001, 4'h1); rd(0); go("R2");
        ev(3'd1, 3'd2, 2'd2, 32'h2222_0000, 12'h002, 4'h2); rd(0); go("R2");
        ev(3'd0, 3'd3, 2'd3, 32'h3333_0000, 12'h003, 4'h3); rd(1); go("R6");
        rd(0); go("R2");
        rd(2); go("R6");
        rd(3); go("R6");

        // R7: clear ignored without bit0, then clear
        wr(1, 32'hFFFF_FFFE); go("R7");
        rd(1); go("R7");
        wr(1, 32'h1); go("R7");
        rd(1); go("R7");
        rd(2); go("R7");
        // R8: core source gives io=0; R5 captured again
        ev(3'd3, 3'd0, 2'd1, 32'h0000_0040, 12'hFFF, 4'hF); go("R8");
        rd(1); go("R8");
        rd(3); go("R5");
        // R7: clear and event in the same cycle
        wr(1, 32'h1); ev(3'd7, 3'd4, 2'd2, 32'h5555_AAAA, 12'h5A5, 4'h6); go("R7");
        rd(1); go("R7");
        rd(2); go("R7");

        // R4: counter clear behaviour
        wr(0, 32'hFFFF_FFFE); go("R4");
        rd(0); go("R4");
        wr(0, 32'h1); go("R4");
        rd(0); go("R4");
        ev(3'd0, 3'd0, 2'd0, 32'h10, 12'h0, 4'h0); go("R4");
        wr(0, 32'h1); ev(3'd0, 3'd0, 2'd1, 32'h10, 12'h0, 4'h0); go("R4");
        rd(0); go("R4");

        // R3: saturation of the uncorrectable count
        for (int n = 0; n < 65540; n++) begin
            ev(3'd1, 3'd0, 2'd2, 32'h40, 12'h0, 4'h0); rd(0); go("R3");
        end
        rd(0); go("R3");
        wr(0, 32'h1); go("R4");

        // R9/R10/R11: injection
        wr(5, 32'h0); go("R10");
        wr(4, 32'h0000_00F0); go("R9");
        rd(4); go("R9");
        wr(5, 32'h0000_1000 | 32'h1); go("R10");
        rd(5); go("R10");
        wr(4, 32'hFFFF_FFFF); go("R9");
        rd(4); go("R9");
        acc_valid = 1; acc_addr = 32'h0000_2000; rd(5); go("R10");
        acc_valid = 1; acc_addr = 32'h0000_1003; rd(5); go("R10");
        rd(5); go("R11");
        acc_valid = 1; acc_addr = 32'h0000_1000; go("R11");
        // R11: control write wins over a same-cycle hit
        wr(5, 32'h0000_1001); go("R11");
        acc_valid = 1; acc_addr = 32'h0000_1000; wr(5, 32'h0000_1001); go("R11");
        rd(5); go("R11");
        acc_valid = 1; acc_addr = 32'h0000_1000; rd(5); go("R11");
        rd(5); go("R11");
        // R1: unused indices still zero
        rd(6); go("R1");
        rd(7); go("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule